// File: doc/BRIEF.md
# Processor bus command controller

This block sits between a 16-bit processor and its buses. It watches the three status lines that the processor drives for each bus cycle. From them it produces active-low command strobes for memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also produces two early write strobes, one for memory and one for I/O. Besides the strobes it drives an address latch pulse, a data-transceiver enable, a transfer direction line and a second transceiver enable for a dedicated I/O bus. Each command strobe has its own drive-enable bit, which models a three-state output.

A bus cycle starts on the first clock edge that samples a non-idle status code. The cycle then steps through three states: latch, early, late. Commands are subject to arbitration. In shared-bus operation every command waits until the grant input has been low for a set number of clocks. With the I/O-bus strap high, the I/O-side commands skip arbitration and steer the dedicated I/O transceiver instead of the main one. A command-enable input can mute all strobes and both transceiver enables at any time.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: While `status` is 3'b111 (idle), all seven command strobes are high; after reset the strobes are high, `addr_strobe`, `data_en` and `periph_en` are low, and `xmit_dir` is low.
- R2: On the first clock edge that samples a non-idle status after idle, `addr_strobe` goes high for exactly one clock.
- R3: Read strobes and both early write strobes go low from the second clock of the cycle and stay low until the status returns to idle.
- R4: The memory write and I/O write strobes go low one clock later than the early write strobes, from the third clock of the cycle.
- R5: `xmit_dir` is set at the start of each cycle (high for codes 010 and 110, low otherwise) and holds its value between cycles; `data_en` is high only from the second clock of a cycle, so it never overlaps a change of `xmit_dir`.
- R6: With `cmd_en` low, every strobe is high and both `data_en` and `periph_en` are low.
- R7: With `io_bus_mode` low, no strobe goes low until `addr_en_n` has been sampled low on GRANT_DELAY consecutive clock edges.
- R8: `cmd_oe` bit order is {int_ack, adv_io_wr, io_wr, io_rd, adv_mem_wr, mem_wr, mem_rd} from bit 6 down to bit 0; a bit is high while `addr_en_n` is low and drops at once when `addr_en_n` is high, except as R9 states.
- R9: With `io_bus_mode` high, the I/O read, I/O write, early I/O write and interrupt acknowledge strobes ignore `addr_en_n`, their `cmd_oe` bits stay high, and those cycles drive `periph_en` instead of `data_en`; memory commands still obey R7.
- R10: Status codes are 000 interrupt acknowledge (read timing on `int_ack_n`), 001 I/O read, 010 I/O write, 011 halt (no strobe and no `data_en`), 100 code fetch (memory read), 101 memory read, 110 memory write, 111 idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| status | input | 3 | Processor cycle status code |
| addr_en_n | input | 1 | Arbitration grant, active low |
| cmd_en | input | 1 | Command enable; low mutes commands and transceiver enables |
| io_bus_mode | input | 1 | Strap: high selects the dedicated I/O bus operation |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| adv_mem_wr_n | output | 1 | Early memory write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| adv_io_wr_n | output | 1 | Early I/O write strobe |
| int_ack_n | output | 1 | Interrupt acknowledge strobe |
| cmd_oe | output | 7 | Per-strobe drive enable |
| addr_strobe | output | 1 | Address latch pulse |
| data_en | output | 1 | Main data transceiver enable |
| xmit_dir | output | 1 | Transfer direction, high for writes |
| periph_en | output | 1 | I/O bus transceiver enable |

## Verification
The hardest case to reach is a command that is already in its late state while the grant is still counting, so that the strobe appears only some clocks into the cycle. The stimulus gets there by lowering `addr_en_n` on the same clock as the status leaves idle, and then by raising it in the middle of a cycle. The bench also runs the same I/O cycles with the strap high and the grant withheld. This shows that the bypass covers only the I/O-side strobes, while a memory cycle in that mode stays silent.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [2:0] {
        ST_INTA    = 3'b000,
        ST_IORD    = 3'b001,
        ST_IOWR    = 3'b010,
        ST_HALT    = 3'b011,
        ST_FETCH   = 3'b100,
        ST_MEMRD   = 3'b101,
        ST_MEMWR   = 3'b110,
        ST_PASSIVE = 3'b111
    } bus_status_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LATCH = 2'd1,
        PH_EARLY = 2'd2,
        PH_LATE  = 2'd3
    } phase_e;

    localparam int NUM_CMD   = 7;
    localparam int CMD_MRD   = 0;
    localparam int CMD_MWR   = 1;
    localparam int CMD_AMW   = 2;
    localparam int CMD_IORD  = 3;
    localparam int CMD_IOWR  = 4;
    localparam int CMD_AIOW  = 5;
    localparam int CMD_INTA  = 6;
    localparam logic [NUM_CMD-1:0] IO_SIDE_MASK = 7'b111_1000;

    typedef struct packed {
        logic is_idle;
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
        logic int_ack;
        logic is_write;
        logic io_path;
        logic has_cmd;
    } decode_t;

    typedef struct packed {
        phase_e  phase;
        decode_t kind;
        logic    dir;
    } seq_t;

endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
    import bcc_pkg::*;
(
    input  logic [2:0] status,
    output decode_t    dec
);
    always_comb begin
        dec = '0;
        unique case (bus_status_e'(status))
            ST_INTA:  begin dec.int_ack = 1'b1; dec.io_path = 1'b1; dec.has_cmd = 1'b1; end
            ST_IORD:  begin dec.io_rd   = 1'b1; dec.io_path = 1'b1; dec.has_cmd = 1'b1; end
            ST_IOWR:  begin dec.io_wr   = 1'b1; dec.io_path = 1'b1; dec.has_cmd = 1'b1;
                            dec.is_write = 1'b1; end
            ST_HALT:  ;
            ST_FETCH: begin dec.mem_rd  = 1'b1; dec.has_cmd = 1'b1; end
            ST_MEMRD: begin dec.mem_rd  = 1'b1; dec.has_cmd = 1'b1; end
            ST_MEMWR: begin dec.mem_wr  = 1'b1; dec.has_cmd = 1'b1; dec.is_write = 1'b1; end
            default:  dec.is_idle = 1'b1;
        endcase
    end
endmodule

// File: rtl/bcc_sequencer.sv
module bcc_sequencer
    import bcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] status,
    output phase_e     phase_q,
    output decode_t    kind_q,
    output logic       dir_q,
    output logic       idle_now
);
    decode_t dec;
    seq_t    s_d, s_q;

    bcc_decode u_dec (.status(status), .dec(dec));

    assign idle_now = dec.is_idle;

    always_comb begin
        s_d = s_q;
        if (dec.is_idle) begin
            s_d.phase = PH_IDLE;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    s_d.phase = PH_LATCH;
                    s_d.kind  = dec;
                    s_d.dir   = dec.is_write;
                end
                PH_LATCH: s_d.phase = PH_EARLY;
                default:  s_d.phase = PH_LATE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, kind: '0, dir: 1'b0};
        else        s_q <= s_d;
    end

    assign phase_q = s_q.phase;
    assign kind_q  = s_q.kind;
    assign dir_q   = s_q.dir;

    // R2: the latch state lasts a single clock
    a_r2_latch_once: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_LATCH) |=> (s_q.phase != PH_LATCH));

    // R5: direction only moves when a cycle has just begun
    a_r5_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_LATCH) |-> $stable(s_q.dir));
endmodule

// File: rtl/bcc_grant_timer.sv
module bcc_grant_timer #(
    parameter int GRANT_DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_en_n,
    output logic granted
);
    localparam int CW = (GRANT_DELAY > 0) ? $clog2(GRANT_DELAY + 1) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(GRANT_DELAY);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (addr_en_n)           cnt_d = '0;
        else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign granted = !addr_en_n && (cnt_q == LIMIT);

    generate
        if (GRANT_DELAY > 0) begin : g_settle_chk
            // R7: a grant that has just arrived is not yet usable
            a_r7_settle: assert property (@(posedge clk) disable iff (!rst_n)
                (!addr_en_n && $past(addr_en_n)) |-> !granted);
        end
    endgenerate
endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
    import bcc_pkg::*;
#(
    parameter int GRANT_DELAY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] status,
    input  logic       addr_en_n,
    input  logic       cmd_en,
    input  logic       io_bus_mode,
    output logic       mem_rd_n,
    output logic       mem_wr_n,
    output logic       adv_mem_wr_n,
    output logic       io_rd_n,
    output logic       io_wr_n,
    output logic       adv_io_wr_n,
    output logic       int_ack_n,
    output logic [6:0] cmd_oe,
    output logic       addr_strobe,
    output logic       data_en,
    output logic       xmit_dir,
    output logic       periph_en
);
    phase_e  phase_q;
    decode_t kind_q;
    logic    dir_q, idle_now, granted;
    logic    live, early, late, mem_ok, io_ok, io_route;
    logic [NUM_CMD-1:0] act;

    bcc_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .status(status),
        .phase_q(phase_q), .kind_q(kind_q), .dir_q(dir_q), .idle_now(idle_now)
    );

    bcc_grant_timer #(.GRANT_DELAY(GRANT_DELAY)) u_grant (
        .clk(clk), .rst_n(rst_n), .addr_en_n(addr_en_n), .granted(granted)
    );

    always_comb begin
        live     = cmd_en && !idle_now;
        early    = (phase_q == PH_EARLY) || (phase_q == PH_LATE);
        late     = (phase_q == PH_LATE);
        mem_ok   = granted;
        io_ok    = io_bus_mode || granted;
        io_route = io_bus_mode && kind_q.io_path;

        act           = '0;
        act[CMD_MRD]  = live && early && kind_q.mem_rd  && mem_ok;
        act[CMD_MWR]  = live && late  && kind_q.mem_wr  && mem_ok;
        act[CMD_AMW]  = live && early && kind_q.mem_wr  && mem_ok;
        act[CMD_IORD] = live && early && kind_q.io_rd   && io_ok;
        act[CMD_IOWR] = live && late  && kind_q.io_wr   && io_ok;
        act[CMD_AIOW] = live && early && kind_q.io_wr   && io_ok;
        act[CMD_INTA] = live && early && kind_q.int_ack && io_ok;
    end

    generate
        for (genvar i = 0; i < NUM_CMD; i++) begin : g_oe
            if (IO_SIDE_MASK[i]) begin : g_io_side
                assign cmd_oe[i] = io_bus_mode || !addr_en_n;
            end else begin : g_mem_side
                assign cmd_oe[i] = !addr_en_n;
            end
        end
    endgenerate

    assign mem_rd_n     = !act[CMD_MRD];
    assign mem_wr_n     = !act[CMD_MWR];
    assign adv_mem_wr_n = !act[CMD_AMW];
    assign io_rd_n      = !act[CMD_IORD];
    assign io_wr_n      = !act[CMD_IOWR];
    assign adv_io_wr_n  = !act[CMD_AIOW];
    assign int_ack_n    = !act[CMD_INTA];

    assign addr_strobe = (phase_q == PH_LATCH);
    assign xmit_dir    = dir_q;
    assign data_en     = live && early && kind_q.has_cmd && !io_route;
    assign periph_en   = live && early && io_route;

    // R1: idle status keeps every strobe high
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 3'b111) |-> (&{mem_rd_n, mem_wr_n, adv_mem_wr_n, io_rd_n,
                                   io_wr_n, adv_io_wr_n, int_ack_n}));

    // R4: a normal write strobe is always covered by its early strobe
    a_r4_write_inside_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n |-> !adv_mem_wr_n) and (!io_wr_n |-> !adv_io_wr_n));

    // R5: a transceiver enable never coincides with the latch pulse
    a_r5_den_after_dir: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |-> (!data_en && !periph_en));

    // R6: command enable low mutes every command output
    a_r6_cen_mute: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_en |-> (&{mem_rd_n, mem_wr_n, adv_mem_wr_n, io_rd_n, io_wr_n,
                      adv_io_wr_n, int_ack_n} && !data_en && !periph_en));

    // R8: withdrawn grant in shared-bus mode releases all drivers
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_en_n && !io_bus_mode) |-> (cmd_oe == '0));

    // R7: in shared-bus mode no strobe is low without the grant
    a_r7_wait_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_en_n && !io_bus_mode) |-> (&{mem_rd_n, mem_wr_n, adv_mem_wr_n,
                                            io_rd_n, io_wr_n, adv_io_wr_n, int_ack_n}));
endmodule

// File: tb/tb_bus_cmd_ctrl.sv
module tb_bus_cmd_ctrl;
    localparam int D = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] status = 3'b111;
    logic addr_en_n = 1'b1, cmd_en = 1'b1, io_bus_mode = 1'b0;
    logic mem_rd_n, mem_wr_n, adv_mem_wr_n, io_rd_n, io_wr_n, adv_io_wr_n, int_ack_n;
    logic [6:0] cmd_oe;
    logic addr_strobe, data_en, xmit_dir, periph_en;

    always #5 clk = ~clk;

    bus_cmd_ctrl #(.GRANT_DELAY(D)) dut (
        .clk(clk), .rst_n(rst_n), .status(status), .addr_en_n(addr_en_n),
        .cmd_en(cmd_en), .io_bus_mode(io_bus_mode),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .adv_mem_wr_n(adv_mem_wr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .adv_io_wr_n(adv_io_wr_n),
        .int_ack_n(int_ack_n), .cmd_oe(cmd_oe), .addr_strobe(addr_strobe),
        .data_en(data_en), .xmit_dir(xmit_dir), .periph_en(periph_en)
    );

    typedef struct {
        logic [17:0] exp;
        string       tag;
    } item_t;

    item_t queue_q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench model state
    int  ph = 0;
    int  cnt = 0;
    int  kind = 7;
    bit  dir = 1'b0;

    function automatic logic [17:0] observed();
        return {mem_rd_n, mem_wr_n, adv_mem_wr_n, io_rd_n, io_wr_n, adv_io_wr_n,
                int_ack_n, cmd_oe, addr_strobe, data_en, xmit_dir, periph_en};
    endfunction

    task automatic step(input logic [2:0] st, input logic aen, input logic cen,
                        input logic iob, input string tag);
        item_t it;
        bit idle, live, early, late, rdy, memok, iook, route, hascmd;
        logic [6:0] act, oe;
        @(negedge clk);
        status = st; addr_en_n = aen; cmd_en = cen; io_bus_mode = iob;
        idle = (st == 3'b111);
        cnt = aen ? 0 : ((cnt == D) ? D : cnt + 1);
        if (idle) ph = 0;
        else if (ph == 0) begin
            ph = 1; kind = int'(st); dir = (st == 3'b010) || (st == 3'b110);
        end else if (ph < 3) ph = ph + 1;
        rdy    = !aen && (cnt == D);
        live   = cen && !idle;
        early  = (ph >= 2);
        late   = (ph == 3);
        memok  = rdy;
        iook   = iob || rdy;
        route  = iob && (kind <= 2);
        hascmd = (kind != 3) && (kind != 7);
        act = '0;
        act[0] = live && early && (kind == 4 || kind == 5) && memok;
        act[1] = live && late  && (kind == 6) && memok;
        act[2] = live && early && (kind == 6) && memok;
        act[3] = live && early && (kind == 1) && iook;
        act[4] = live && late  && (kind == 2) && iook;
        act[5] = live && early && (kind == 2) && iook;
        act[6] = live && early && (kind == 0) && iook;
        for (int i = 0; i < 7; i++) oe[i] = (i >= 3 && iob) ? 1'b1 : !aen;
        it.exp = {!act[0], !act[1], !act[2], !act[3], !act[4], !act[5], !act[6],
                  oe, (ph == 1), live && early && hascmd && !route, dir,
                  live && early && route};
        it.tag = tag;
        queue_q.push_back(it);
    endtask

    // monitor: compare each expected item one step after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (queue_q.size() > 0) begin
                item_t it;
                logic [17:0] got;
                it  = queue_q.pop_front();
                got = observed();
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %b expected %b", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state observed directly
        checks++;
        if (observed() !== {7'h7f, 7'h00, 4'b0000}) begin
            errors++;
            $display("FAIL R1: got %b expected %b", observed(), {7'h7f, 7'h00, 4'b0000});
        end
        rst_n = 1'b1;
        repeat (2) step(3'b111, 1'b1, 1'b1, 1'b0, "R1");
        // grant settles while idle
        repeat (D + 1) step(3'b111, 1'b0, 1'b1, 1'b0, "R8");
        // R2 R3 R10: memory read
        repeat (4) step(3'b101, 1'b0, 1'b1, 1'b0, "R3");
        step(3'b111, 1'b0, 1'b1, 1'b0, "R1");
        // R4 R5: memory write, direction high
        repeat (4) step(3'b110, 1'b0, 1'b1, 1'b0, "R4");
        step(3'b111, 1'b0, 1'b1, 1'b0, "R5");
        step(3'b111, 1'b0, 1'b1, 1'b0, "R5");
        // R10: code fetch, halt, interrupt acknowledge
        repeat (3) step(3'b100, 1'b0, 1'b1, 1'b0, "R10");
        step(3'b111, 1'b0, 1'b1, 1'b0, "R10");
        repeat (3) step(3'b011, 1'b0, 1'b1, 1'b0, "R10");
        step(3'b111, 1'b0, 1'b1, 1'b0, "R10");
        repeat (3) step(3'b000, 1'b0, 1'b1, 1'b0, "R10");
        step(3'b111, 1'b0, 1'b1, 1'b0, "R10");
        // R7: grant arrives with the cycle, strobes wait for the count
        step(3'b111, 1'b1, 1'b1, 1'b0, "R8");
        repeat (6) step(3'b010, 1'b0, 1'b1, 1'b0, "R7");
        step(3'b111, 1'b0, 1'b1, 1'b0, "R7");
        // R8: grant withdrawn mid cycle
        repeat (3) step(3'b001, 1'b0, 1'b1, 1'b0, "R8");
        repeat (2) step(3'b001, 1'b1, 1'b1, 1'b0, "R8");
        step(3'b111, 1'b1, 1'b1, 1'b0, "R8");
        // R9: I/O bus mode, no grant, I/O commands proceed
        repeat (4) step(3'b010, 1'b1, 1'b1, 1'b1, "R9");
        step(3'b111, 1'b1, 1'b1, 1'b1, "R9");
        repeat (3) step(3'b000, 1'b1, 1'b1, 1'b1, "R9");
        step(3'b111, 1'b1, 1'b1, 1'b1, "R9");
        // R9: memory cycle in I/O bus mode still waits for grant
        repeat (3) step(3'b101, 1'b1, 1'b1, 1'b1, "R9");
        repeat (D + 2) step(3'b101, 1'b0, 1'b1, 1'b1, "R9");
        step(3'b111, 1'b0, 1'b1, 1'b1, "R9");
        // R6: command enable low mutes a granted cycle
        repeat (4) step(3'b110, 1'b0, 1'b0, 1'b0, "R6");
        repeat (2) step(3'b110, 1'b0, 1'b1, 1'b0, "R6");
        step(3'b111, 1'b0, 1'b1, 1'b0, "R6");
        repeat (3) step(3'b001, 1'b1, 1'b0, 1'b1, "R6");
        step(3'b111, 1'b1, 1'b1, 1'b1, "R6");
        // R2: back-to-back cycles each give one latch pulse
        repeat (2) step(3'b001, 1'b1, 1'b1, 1'b1, "R2");
        step(3'b111, 1'b1, 1'b1, 1'b1, "R2");
        repeat (2) step(3'b010, 1'b1, 1'b1, 1'b1, "R2");
        step(3'b111, 1'b1, 1'b1, 1'b1, "R2");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule